// File: doc/BRIEF.md
# Card Presence and Fault Interrupt Line

This block drives a single active-low interrupt line toward a host controller. Its inputs are a card-present flag, a vector of fault flags, and an active-low session command. The presence and fault flags come from other clock domains, so each passes through a two-flop synchroniser before the block uses it.

The meaning of the line depends on the session command. When the command is high, no session is active. The line then reports presence: it is high with a card inserted and low with none, and faults are ignored.

When the command is low, a session is active. If the card is pulled out or any fault flag rises, the line drops. In that same cycle the block emits a one-cycle request to start deactivation. The line then stays low until the host releases the session command. At most one deactivation request is issued per session.

Top module: `card_irq_ctrl`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, irq_n_o is 0 and deact_start_o is 0.
- R2: With sess_n_i high, irq_n_o equals present_i delayed by three rising clock edges: two synchroniser stages and the output register. Present (1) gives irq_n_o = 1, absent (0) gives irq_n_o = 0.
- R3: With sess_n_i high, no value or change of fault_i alters irq_n_o.
- R4: deact_start_o is 0 on every edge where sess_n_i was high at the preceding edge.
- R5: With sess_n_i low, a synchronised present_i of 0 drives irq_n_o to 0 at the next edge.
- R6: With sess_n_i low, any single bit of fault_i at 1 drives irq_n_o to 0, three edges after it is applied.
- R7: deact_start_o is 1 for exactly one cycle, and that cycle is the one in which irq_n_o first goes to 0 inside the session.
- R8: Once irq_n_o has dropped inside a session, it stays 0 while sess_n_i stays low. This holds even if the card returns or the faults clear.
- R9: A session, meaning a continuous stretch of sess_n_i low, produces at most one deact_start_o pulse.
- R10: One edge after sess_n_i returns high, irq_n_o again reflects the synchronised presence. The next session may trip again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| present_i | input | 1 | Card inserted flag, asynchronous |
| fault_i | input | NUM_FAULTS | Fault flags, asynchronous, active high |
| sess_n_i | input | 1 | Session command, low = session active |
| irq_n_o | output | 1 | Active-low interrupt line |
| deact_start_o | output | 1 | One-cycle deactivation start request |

## Verification
The bench toggles faults outside a session. A design that let faults leak through would pull the line low, or would fire a deactivation request with no session active.

Inside a session, the bench re-inserts the card and clears the faults after a trip. A design without the latch would release the line early. A design that re-arms would emit a second pulse in the same session.

The bench also starts a session with no card present, which must trip on the very first cycle of the session. Finally, it trips each fault bit on its own. A reduction that misses one bit would leave the line high for that bit.

// File: rtl/card_irq_pkg.sv
package card_irq_pkg;
  localparam int unsigned SYNC_STAGES_DEF = 2;
  localparam int unsigned NUM_FAULTS_DEF  = 4;

  typedef struct packed {
    logic tripped;
    logic irq_n;
    logic deact;
  } trip_state_t;
endpackage

// File: rtl/cirq_sync.sv
module cirq_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= '0;
        else         pipe[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe[s] <= '0;
        else         pipe[s] <= pipe[s-1];
      end
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/cirq_trip.sv
module cirq_trip
  import card_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sess_n_i,
  input  logic present_s_i,
  input  logic fault_any_i,
  output logic irq_n_o,
  output logic deact_o
);
  trip_state_t st_q, st_d;
  logic        trip;

  // trip only on the first bad condition of a session
  assign trip = !sess_n_i && !st_q.tripped && (!present_s_i || fault_any_i);

  always_comb begin
    st_d = st_q;
    if (sess_n_i) begin
      st_d.tripped = 1'b0;
      st_d.irq_n   = present_s_i;
      st_d.deact   = 1'b0;
    end else begin
      st_d.tripped = st_q.tripped | trip;
      st_d.irq_n   = !(st_q.tripped | trip);
      st_d.deact   = trip;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= st_d;
  end

  assign irq_n_o = st_q.irq_n;
  assign deact_o = st_q.deact;

  p_no_deact_outside_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_n_i |=> !deact_o);

  p_deact_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_o |=> !deact_o);

  p_deact_with_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_o |-> !irq_n_o);

  p_trip_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sess_n_i && irq_n_o && (!present_s_i || fault_any_i)) |=> (!irq_n_o && deact_o));

  p_latched_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sess_n_i && $past(!sess_n_i) && !irq_n_o) |=> !irq_n_o);

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sess_n_i |=> (irq_n_o == $past(present_s_i)));
endmodule

// File: rtl/card_irq_ctrl.sv
module card_irq_ctrl
  import card_irq_pkg::*;
#(
  parameter int unsigned NUM_FAULTS  = NUM_FAULTS_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  present_i,
  input  logic [NUM_FAULTS-1:0] fault_i,
  input  logic                  sess_n_i,
  output logic                  irq_n_o,
  output logic                  deact_start_o
);
  localparam int unsigned SYNC_W = NUM_FAULTS + 1;

  logic [SYNC_W-1:0]     raw, synced;
  logic                  present_s;
  logic [NUM_FAULTS-1:0] fault_s;
  logic                  fault_any;

  assign raw = {fault_i, present_i};

  cirq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw),
    .q_o    (synced)
  );

  assign present_s = synced[0];
  assign fault_s   = synced[SYNC_W-1:1];
  assign fault_any = |fault_s;

  cirq_trip u_trip (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sess_n_i    (sess_n_i),
    .present_s_i (present_s),
    .fault_any_i (fault_any),
    .irq_n_o     (irq_n_o),
    .deact_o     (deact_start_o)
  );

  p_reset_r1: assert property (@(posedge clk_i) !rst_ni |=> (!irq_n_o && !deact_start_o));
endmodule

// File: tb/sim_card_irq_ctrl.sv
module sim_card_irq_ctrl;
  localparam int NF = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          present = 1'b0;
  logic [NF-1:0] fault = '0;
  logic          sess_n = 1'b1;
  logic          irq_n, deact;

  int    checks = 0;
  int    errors = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // behavioural reference
  bit pq[$];
  bit fq[$];
  bit m_tripped = 0, m_irq_n = 0, m_deact = 0;
  int sess_pulses = 0;

  always #10 clk = ~clk;

  card_irq_ctrl #(.NUM_FAULTS(NF)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .present_i(present), .fault_i(fault),
    .sess_n_i(sess_n), .irq_n_o(irq_n), .deact_start_o(deact)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq = '{0, 0};
      fq = '{0, 0};
      m_tripped = 0; m_irq_n = 0; m_deact = 0;
    end else begin
      bit ps, fa, trip;
      ps = pq.pop_front();
      fa = fq.pop_front();
      pq.push_back(present);
      fq.push_back(|fault);
      if (sess_n) begin
        m_tripped = 0; m_irq_n = ps; m_deact = 0;
      end else begin
        trip = !m_tripped && (!ps || fa);
        m_deact = trip;
        m_tripped = m_tripped || trip;
        m_irq_n = !m_tripped;
      end
    end
  end

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%b exp=%b @%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "irq_n_o", irq_n, m_irq_n);
      check(cur_req, "deact_start_o", deact, m_deact);
      if (deact === 1'b1) sess_pulses++;
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic end_session();
    sess_n = 1'b1;
    step(1);
    // R9: at most one request per session
    check("R9", "pulses_per_session", sess_pulses <= 1, 1'b1);
    sess_pulses = 0;
  endtask

  initial begin
    step(3);
    check("R1", "irq_n_o in reset", irq_n, 1'b0);
    check("R1", "deact in reset", deact, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1", "irq_n_o after reset", irq_n, 1'b0);

    cur_req = "R2";
    present = 1; step(2);
    check("R2", "not yet visible", irq_n, 1'b0);
    step(1);
    check("R2", "visible after 3 edges", irq_n, 1'b1);
    present = 0; step(5);
    present = 1; step(5);

    cur_req = "R3";
    for (int k = 0; k < 16; k++) begin
      fault = NF'(k); step(2);
    end
    fault = '0; present = 0; step(2);
    fault = '1; step(4);
    cur_req = "R4";
    fault = 4'b0101; present = 1; step(6);
    fault = '0; step(4);

    // session tripped by card removal
    cur_req = "R5";
    sess_n = 0; step(5);
    present = 0; step(3);
    check("R5", "irq_n_o low on removal", irq_n, 1'b0);
    check("R7", "deact pulse with drop", deact, 1'b1);
    cur_req = "R8";
    step(1);
    check("R7", "deact single cycle", deact, 1'b0);
    present = 1; step(8);
    check("R8", "still latched", irq_n, 1'b0);
    cur_req = "R10";
    end_session();
    check("R10", "presence resumes", irq_n, 1'b1);
    step(3);

    // each fault bit alone
    for (int b = 0; b < NF; b++) begin
      cur_req = "R6";
      sess_n = 0; step(4);
      fault[b] = 1'b1; step(3);
      check("R6", "fault bit drops irq", irq_n, 1'b0);
      fault[b] = 1'b0;
      cur_req = "R9";
      step(3);
      fault = '1; step(4);
      fault = '0; step(3);
      cur_req = "R10";
      end_session();
      step(3);
    end

    // session started with no card
    cur_req = "R5";
    present = 0; step(4);
    sess_n = 0; step(1);
    check("R5", "immediate trip", deact, 1'b1);
    step(4);
    end_session();
    check("R10", "absent after release", irq_n, 1'b0);
    present = 1; step(5);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule